// File: doc/BRIEF.md
# Watchdog and Periodic Tick Timer

This block divides the bus clock with a free-running prescaler and produces a periodic tick. Each tick sets a sticky flag that can raise an interrupt request. The same tick also advances a watchdog counter. Software enables the watchdog once through a control register. It then has to keep the watchdog alive by writing to a dedicated clear address before eight ticks have passed. If it misses that deadline, the block issues a one-cycle system reset request and puts its own control state back to the power-up state.

A single 2-bit rate field sets the tick period and, with it, the watchdog timeout. Each step of the field doubles both. The watchdog does not count while the CPU is in wait or stop. The prescaler keeps running in wait, so periodic ticks can still wake the CPU. In stop the prescaler halts. After a wake from stop, the prescaler and the watchdog stay frozen for a fixed settling delay before counting resumes.

Top module: `wdog_tick_unit`

## Requirements
- R1: After `rst_n` is low, the control register reads 0x00, and `tick_flag`, `tick_irq` and `rst_req` are all 0.
- R2: Writing the control address (default 0x001C) with bit 2 set enables the watchdog. A later write with bit 2 clear leaves bit 2 reading 1, and the timeout still happens on schedule.
- R3: A write to the clear address (default 0xFFF0) with bit 0 equal to 0 restarts the watchdog count. If this write lands on the same cycle as a tick, that tick is not counted. A write to the clear address with bit 0 equal to 1 has no effect on the timeout.
- R4: The prescaler starts from 0 at reset release. It adds one on every running cycle. A tick occurs on the cycle in which the low BASE_LOG2+rate bits of the prescaler are all ones, so the tick period is 2^(BASE_LOG2+rate) cycles. The rate field is control bits 1:0.
- R5: A tick sets `tick_flag`, which reads back as control bit 7. Writing the control register with bit 6 set clears the flag. If that write falls on the same cycle as a tick, the tick wins. `tick_irq` equals the flag gated by control bit 5.
- R6: While enabled, the watchdog issues `rst_req` on the 8th tick it counts after the last clear or enable. This is between 7 and 8 tick periods after the clear. `rst_req` is high for exactly one cycle, the cycle after that tick.
- R7: A timeout clears the whole control register, the flag and the watchdog count, and the clear takes priority over the tick that caused the timeout. No further reset request follows until the watchdog is enabled again. The prescaler keeps its phase.
- R8: While `wait_mode` is high, the watchdog ignores ticks. The prescaler and the flag keep running. Counting resumes on the first cycle after `wait_mode` falls.
- R9: A `stop_enter` pulse freezes the prescaler and the watchdog from the next cycle on. A `stop_wake` pulse ends the stop. The prescaler and the watchdog then stay frozen for STOP_DELAY (default 4064) more cycles.
- R10: A write to any other address changes nothing. A read of any address other than the control address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Combinational read data |
| wait_mode | input | 1 | High while the CPU waits |
| stop_enter | input | 1 | One-cycle pulse entering stop |
| stop_wake | input | 1 | One-cycle pulse leaving stop |
| tick_flag | output | 1 | Sticky periodic tick flag |
| tick_irq | output | 1 | Flag gated by the interrupt enable |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Every register effect shows up one cycle after the write edge that carries it. The flag rises on the cycle after its tick edge, and `rst_req` is high only on the cycle after the 8th counted tick edge. The bench numbers the clock edges from reset release and drives all stimulus on falling edges, so each write lands on a known edge index. It predicts the exact edge of each timeout with an arithmetic walk over edge indices. That walk adds one to a model prescaler only on cycles that are not frozen, and counts ticks outside the wait window. The bench then checks the result on the falling edge one cycle later. The flag checks sample on the falling edges just before and just after each tick edge, so an error of one cycle in either direction is reported.

// File: rtl/wdt_pkg.sv
// Shared constants and types for the watchdog / periodic tick timer.
// Assumes an 8-bit data path for the register interface.
package wdt_pkg;
    localparam int DATA_W   = 8;
    localparam int RATE_W   = 2;
    localparam int BIT_FLAG = 7;
    localparam int BIT_ACK  = 6;
    localparam int BIT_IE   = 5;
    localparam int BIT_EN   = 2;

    typedef struct packed {
        logic              flag;
        logic              ie;
        logic              en;
        logic [RATE_W-1:0] rate;
    } ctrl_t;
endpackage

// File: rtl/wdt_prescaler.sv
// Free-running prescaler that produces the periodic tick.
// It counts while run is high. The tick is asserted on the cycle in which
// the low BASE_LOG2+rate bits are all ones. Assumes rate is stable
// between writes.
module wdt_prescaler #(
    parameter int BASE_LOG2 = 14,
    parameter int RATE_W    = 2,
    localparam int NRATES   = 1 << RATE_W,
    localparam int PRE_W    = BASE_LOG2 + NRATES - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick,
    output logic [PRE_W-1:0]  pre_cnt
);
    logic [PRE_W-1:0]  pre_q;
    logic [NRATES-1:0] tap_hit;

    // One all-ones detector per selectable rate.
    for (genvar g = 0; g < NRATES; g++) begin : g_tap
        assign tap_hit[g] = &pre_q[BASE_LOG2+g-1:0];
    end

    assign tick    = run & tap_hit[rate];
    assign pre_cnt = pre_q;

    // Advance the prescaler on every running cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (run)
            pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/wdt_lowpower.sv
// Low-power sequencer. It tracks the stop state and the post-stop settling
// delay, and derives the run enables for the prescaler and the watchdog.
// Assumes stop_enter and stop_wake are single-cycle pulses.
module wdt_lowpower #(
    parameter int STOP_DELAY = 4064,
    localparam int DLY_W     = $clog2(STOP_DELAY + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_mode,
    input  logic stop_enter,
    input  logic stop_wake,
    output logic pre_run,
    output logic wd_run
);
    localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(STOP_DELAY);

    logic             stop_q;
    logic [DLY_W-1:0] dly_q;

    assign pre_run = !stop_q && (dly_q == '0);
    assign wd_run  = pre_run && !wait_mode;

    // Stop state: set on entry, cleared by a wake pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stop_q <= 1'b0;
        else if (stop_q && stop_wake)
            stop_q <= 1'b0;
        else if (stop_enter)
            stop_q <= 1'b1;
    end

    // Settling delay: load on wake, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dly_q <= '0;
        else if (stop_q && stop_wake)
            dly_q <= DLY_LOAD;
        else if (dly_q != '0)
            dly_q <= dly_q - 1'b1;
    end
endmodule

// File: rtl/wdt_counter.sv
// Watchdog tick counter. While enabled and running, it counts ticks. It
// flags a timeout on the TIMEOUT_TICKS-th tick after a clear and registers
// a one-cycle reset request. A clear on the same cycle as a tick wins.
module wdt_counter #(
    parameter int TIMEOUT_TICKS = 8,
    localparam int CNT_W        = $clog2(TIMEOUT_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enabled,
    input  logic             tick,
    input  logic             wd_run,
    input  logic             clear_hit,
    output logic             timeout_now,
    output logic             rst_req,
    output logic [CNT_W-1:0] wd_cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             req_q;
    logic             counting;

    assign counting    = enabled && tick && wd_run && !clear_hit;
    assign timeout_now = counting && (cnt_q == LAST);
    assign rst_req     = req_q;
    assign wd_cnt      = cnt_q;

    // Count accepted ticks; restart on a clear or a timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear_hit || timeout_now)
            cnt_q <= '0;
        else if (counting)
            cnt_q <= cnt_q + 1'b1;
    end

    // Register the reset request as a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= 1'b0;
        else
            req_q <= timeout_now;
    end
endmodule

// File: rtl/wdt_regs.sv
// Register file. It decodes the control and clear addresses, holds the
// sticky enable, the rate, the interrupt enable and the tick flag, and
// serves reads. A timeout puts the control state back to its reset value.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 16'h001C,
    parameter logic [ADDR_W-1:0] CLEAR_ADDR = 16'hFFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              tick,
    input  logic              timeout_now,
    output logic [DATA_W-1:0] rd_data,
    output logic              clear_hit,
    output ctrl_t             ctrl
);
    ctrl_t ctrl_q;
    logic  ctrl_hit;

    assign ctrl_hit  = wr_en && (wr_addr == CTRL_ADDR);
    assign clear_hit = wr_en && (wr_addr == CLEAR_ADDR) && !wr_data[0];
    assign ctrl      = ctrl_q;

    // Control state update: timeout reset first, then writes and the tick flag.
    always_ff @(posedge clk) begin
        if (!rst_n || timeout_now) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_hit) begin
                ctrl_q.rate <= wr_data[RATE_W-1:0];
                ctrl_q.ie   <= wr_data[BIT_IE];
                if (wr_data[BIT_EN])
                    ctrl_q.en <= 1'b1;
            end
            if (tick)
                ctrl_q.flag <= 1'b1;
            else if (ctrl_hit && wr_data[BIT_ACK])
                ctrl_q.flag <= 1'b0;
        end
    end

    // Read mux: only the control address returns data.
    always_comb begin
        rd_data = '0;
        if (rd_addr == CTRL_ADDR) begin
            rd_data[BIT_FLAG]     = ctrl_q.flag;
            rd_data[BIT_IE]       = ctrl_q.ie;
            rd_data[BIT_EN]       = ctrl_q.en;
            rd_data[RATE_W-1:0]   = ctrl_q.rate;
        end
    end
endmodule

// File: rtl/wdog_tick_unit.sv
// Top of the watchdog / periodic tick timer. Wires the prescaler, the
// low-power sequencer, the watchdog counter and the register file together.
// Assumes a single bus clock and a synchronous active-low reset.
module wdog_tick_unit #(
    parameter int                ADDR_W        = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR     = 16'h001C,
    parameter logic [ADDR_W-1:0] CLEAR_ADDR    = 16'hFFF0,
    parameter int                BASE_LOG2     = 14,
    parameter int                TIMEOUT_TICKS = 8,
    parameter int                STOP_DELAY    = 4064,
    localparam int               PRE_W         = BASE_LOG2 + (1 << wdt_pkg::RATE_W) - 1,
    localparam int               CNT_W         = $clog2(TIMEOUT_TICKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              wait_mode,
    input  logic              stop_enter,
    input  logic              stop_wake,
    output logic              tick_flag,
    output logic              tick_irq,
    output logic              rst_req
);
    wdt_pkg::ctrl_t   ctrl;
    logic             pre_run;
    logic             wd_run;
    logic             tick;
    logic             clear_hit;
    logic             timeout_now;
    logic [PRE_W-1:0] pre_cnt;
    logic [CNT_W-1:0] wd_cnt;

    assign tick_flag = ctrl.flag;
    assign tick_irq  = ctrl.flag & ctrl.ie;

    wdt_lowpower #(.STOP_DELAY(STOP_DELAY)) u_lowpower (
        .clk(clk), .rst_n(rst_n), .wait_mode(wait_mode),
        .stop_enter(stop_enter), .stop_wake(stop_wake),
        .pre_run(pre_run), .wd_run(wd_run)
    );

    wdt_prescaler #(.BASE_LOG2(BASE_LOG2), .RATE_W(wdt_pkg::RATE_W)) u_prescaler (
        .clk(clk), .rst_n(rst_n), .run(pre_run), .rate(ctrl.rate),
        .tick(tick), .pre_cnt(pre_cnt)
    );

    wdt_counter #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_counter (
        .clk(clk), .rst_n(rst_n), .enabled(ctrl.en), .tick(tick),
        .wd_run(wd_run), .clear_hit(clear_hit), .timeout_now(timeout_now),
        .rst_req(rst_req), .wd_cnt(wd_cnt)
    );

    wdt_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .CLEAR_ADDR(CLEAR_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .tick(tick),
        .timeout_now(timeout_now), .rd_data(rd_data),
        .clear_hit(clear_hit), .ctrl(ctrl)
    );
endmodule

// File: rtl/wdog_tick_unit_chk.sv
// Property checker for wdog_tick_unit, attached with bind below.
module wdog_tick_unit_chk #(
    parameter int PRE_W = 17,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_req,
    input logic             wd_en,
    input logic             timeout_now,
    input logic             clear_hit,
    input logic             wd_run,
    input logic             pre_run,
    input logic             tick,
    input logic             tick_flag,
    input logic [PRE_W-1:0] pre_cnt,
    input logic [CNT_W-1:0] wd_cnt
);
    assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    assert_rst_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(wd_en));
    assert_en_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_en && !timeout_now) |=> wd_en);
    assert_timeout_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !wd_en);
    assert_clear_zeroes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear_hit |=> (wd_cnt == '0));
    assert_wd_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_run && !clear_hit) |=> $stable(wd_cnt));
    assert_pre_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_run |=> $stable(pre_cnt));
    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !timeout_now) |=> tick_flag);
endmodule

bind wdog_tick_unit wdog_tick_unit_chk #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .wd_en(ctrl.en),
    .timeout_now(timeout_now), .clear_hit(clear_hit), .wd_run(wd_run),
    .pre_run(pre_run), .tick(tick), .tick_flag(tick_flag),
    .pre_cnt(pre_cnt), .wd_cnt(wd_cnt)
);

// File: tb/wdog_tick_unit_tb.sv
module wdog_tick_unit_tb;
    localparam int BASE = 6;
    localparam int DLY  = 4064;
    localparam logic [15:0] A_CTRL  = 16'h001C;
    localparam logic [15:0] A_CLR   = 16'hFFF0;
    localparam logic [15:0] A_OTHER = 16'h0040;

    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [15:0] wr_addr = '0, rd_addr = A_CTRL;
    logic [7:0]  wr_data = '0;
    logic        wait_mode = 1'b0, stop_enter = 1'b0, stop_wake = 1'b0;
    logic [7:0]  rd_data;
    logic        tick_flag, tick_irq, rst_req;
    int          k = 0, checks = 0, errors = 0, wd_cyc = 0;
    bit          done = 1'b0;

    wdog_tick_unit #(.BASE_LOG2(BASE), .STOP_DELAY(DLY)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .wait_mode(wait_mode), .stop_enter(stop_enter), .stop_wake(stop_wake),
        .tick_flag(tick_flag), .tick_irq(tick_irq), .rst_req(rst_req)
    );

    always #10 clk = ~clk;

    // Edge index since reset release; at a falling edge it names the next edge.
    always @(posedge clk) begin
        if (!rst_n) k <= 0;
        else        k <= k + 1;
    end

    always @(posedge clk) begin
        wd_cyc <= wd_cyc + 1;
        if (wd_cyc > 190000 && !done) begin
            errors = errors + 1;
            $display("FAIL run limit: actual %0d cycles expected below 190000", wd_cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; wait_mode = 1'b0;
        stop_enter = 1'b0; stop_wake = 1'b0; rd_addr = A_CTRL;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle_to(input int t);
        while (k < t) @(negedge clk);
    endtask

    task automatic wait_rst(input int limit, output int seen);
        seen = -1;
        while (k < limit) begin
            if (rst_req) begin seen = k; return; end
            @(negedge clk);
        end
    endtask

    // Edge-by-edge walk giving the falling-edge index where rst_req is due.
    function automatic int predict(int e, int r, int wa, int wb, int s, int w);
        int p = 64 << r;
        int pv = 0;
        int n = 0;
        for (int j = 0; j < 200000; j++) begin
            bit frozen, tk, wt;
            frozen = (s >= 0) && (j > s) && (j <= w + DLY);
            tk     = !frozen && ((pv % p) == p - 1);
            wt     = (j >= wa) && (j < wb);
            if (!frozen) pv++;
            if (j > e && tk && !wt) begin
                n++;
                if (n == 8) return j + 1;
            end
        end
        return -1;
    endfunction

    task automatic run_case(input int r, input int clr_at, input int ign_at, input int dis_at,
                            input int wa, input int wb, input int s, input int w,
                            input string req, output int got);
        int exp;
        do_reset();
        wr(A_CTRL, 8'h04 | 8'(r));
        idle_to(clr_at);
        wr(A_CLR, 8'h00);
        if (ign_at >= 0) begin idle_to(ign_at); wr(A_CLR, 8'h01); end
        if (dis_at >= 0) begin
            idle_to(dis_at); wr(A_CTRL, 8'(r));
            chk("R2", "enable bit after zero write", rd_data[2], 1);
        end
        if (wa >= 0) begin idle_to(wa); wait_mode = 1'b1; idle_to(wb); wait_mode = 1'b0; end
        if (s >= 0) begin
            idle_to(s); stop_enter = 1'b1; @(negedge clk); stop_enter = 1'b0;
            idle_to(w); stop_wake = 1'b1; @(negedge clk); stop_wake = 1'b0;
        end
        exp = predict(clr_at, r, wa, wb, s, w);
        wait_rst(exp + 20, got);
        chk(req, "reset request cycle", got, exp);
        @(negedge clk);
        chk("R6", "reset request width", rst_req, 0);
    endtask

    initial begin
        int got, p, t;
        // R1: reset state
        do_reset();
        chk("R1", "control readback", rd_data, 0);
        chk("R1", "flag", tick_flag, 0);
        chk("R1", "irq", tick_irq, 0);
        chk("R1", "reset request", rst_req, 0);

        // R4/R5: tick period per rate, flag, acknowledge, gating, set-wins
        for (int r = 0; r < 4; r++) begin
            p = 64 << r;
            do_reset();
            wr(A_CTRL, 8'h20 | 8'(r));
            idle_to(p - 1);
            chk("R4", "flag before first tick", tick_flag, 0);
            chk("R5", "irq before first tick", tick_irq, 0);
            idle_to(p);
            chk("R4", "flag after first tick", tick_flag, 1);
            chk("R5", "irq with enable", tick_irq, 1);
            chk("R5", "flag readback bit 7", rd_data[7], 1);
            idle_to(p + 5);
            wr(A_CTRL, 8'h60 | 8'(r));
            chk("R5", "flag after acknowledge", tick_flag, 0);
            idle_to(2 * p - 1);
            chk("R4", "flag before second tick", tick_flag, 0);
            idle_to(2 * p);
            chk("R4", "flag after second tick", tick_flag, 1);
            wr(A_CTRL, 8'(r));
            chk("R5", "irq with enable off", tick_irq, 0);
            idle_to(3 * p - 1);
            wr(A_CTRL, 8'h40 | 8'(r));
            chk("R5", "tick beats acknowledge", tick_flag, 1);
        end

        // R6/R3: timeout sweep over rates and clear phases
        for (int r = 0; r < 4; r++) begin
            p = 64 << r;
            run_case(r, p + p - 1, -1, -1, -1, -1, -1, -1, "R3", got); // clear on a tick edge
            run_case(r, p + p - 2, -1, -1, -1, -1, -1, -1, "R6", got); // shortest window
            run_case(r, p + p / 2, -1, -1, -1, -1, -1, -1, "R6", got);
        end

        // R3: clear write with bit 0 set is ignored
        run_case(0, 10, 200, -1, -1, -1, -1, -1, "R3", got);
        // R2: zero write to enable bit is ignored
        run_case(1, 5, -1, 40, -1, -1, -1, -1, "R2", got);
        // R8: wait window hides three ticks
        run_case(0, 1, -1, -1, 100, 292, -1, -1, "R8", got);
        // R9: stop plus settling delay
        run_case(0, 1, -1, -1, -1, -1, 200, 400, "R9", got);
        run_case(2, 50, -1, -1, -1, -1, 300, 301, "R9", got);

        // R7: state after a timeout
        run_case(0, 1, -1, -1, -1, -1, -1, -1, "R6", got);
        t = got - 1;
        chk("R7", "control after timeout", rd_data, 0);
        idle_to(t + 64);
        chk("R7", "flag before next tick", tick_flag, 0);
        idle_to(t + 65);
        chk("R7", "prescaler phase kept", tick_flag, 1);
        wait_rst(k + 600, got);
        chk("R7", "no second reset request", got, -1);

        // R10: other addresses
        do_reset();
        wr(A_CTRL, 8'h21);
        wr(A_OTHER, 8'h04);
        chk("R10", "control after foreign write", rd_data, 8'h21);
        rd_addr = A_OTHER;
        #1;
        chk("R10", "foreign read", rd_data, 0);
        rd_addr = A_CTRL;
        wait_rst(k + 1100, got);
        chk("R10", "no reset request", got, -1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule